// File: doc/BRIEF.md
# Processor Condition-Code Flag Unit

This unit owns the 8-bit processor status register and keeps it up to date. The execution stage gives it, on each accepted operation, the operation code, an operand size (byte, word or long), both source operands and the result that the datapath already produced. For the arithmetic group (add, add-with-carry, subtract, subtract-with-borrow, compare, negate) it derives half-carry, negative, zero, overflow and carry from those values at the selected width. For the register group it loads the whole register from an immediate byte, or combines it with that byte by AND, OR or XOR. Its "store" code leaves the register alone, because the register is always visible on `sr_q`.

The top bit is the interrupt mask. It is forced to 1 on exception entry and gates the maskable interrupt request. The non-maskable request always passes. Two spare bits are plain user storage. The low four flags also leave the block as separate lines for branch-condition logic.

There is no back-pressure. An operation presented with `op_valid` high is always taken at the next rising clock edge, and `op_valid` low means no operation. The datapath itself, instruction decode and interrupt priority live elsewhere.

Top module: `cc_flag_unit`

## Requirements
- R1: An active-low `rst_n` sets the register to 0x80: mask bit 7 is set and all other bits are clear.
- R2: Bit layout: 7 = interrupt mask, 6 = user bit A, 5 = half-carry, 4 = user bit B, 3 = negative, 2 = zero, 1 = overflow, 0 = carry. `op_size` 0 selects byte, 1 selects word, 2 or 3 selects long. For arithmetic codes, negative takes the result's top bit at that width (7, 15 or 31). Zero is set exactly when that slice of `result` is all zeros. Bits above the width are ignored on every operand.
- R3: Arithmetic codes are 1 add, 2 add-with-carry, 3 subtract, 4 subtract-with-borrow, 5 compare (subtract, flags only) and 6 negate (0 minus `src_b`; `src_a` is ignored). Half-carry is the carry (add) or borrow (subtract forms) out of bit 3, 11 or 27 for byte, word or long, and is cleared when there is none.
- R4: Carry is the carry or borrow out of the top bit of the selected width. Overflow is set on two's-complement overflow at that width.
- R5: For codes 2 and 4, zero is cleared when the result is non-zero and otherwise keeps its previous value.
- R6: Arithmetic codes never change bits 7, 6 and 4.
- R7: Code 7 loads `imm` into the register. Codes 9, 10 and 11 replace it with its AND, OR or XOR with `imm`. Code 8 (store) leaves it unchanged. These operations reach every bit, including both user bits and the mask.
- R8: `exc_entry` sets bit 7 at the next edge. If a write or arithmetic operation arrives in the same cycle, bit 7 still ends at 1 and the other bits take the operation's values.
- R9: `irq_grant` is `irq_req` while bit 7 is 0 and is low while bit 7 is 1. Bit 6 has no effect on it. `nmi_grant` follows `nmi_req` at all times.
- R10: With `op_valid` low, or with code 0 or 12 to 15, the register is unchanged.
- R11: `cond_n`, `cond_z`, `cond_v` and `cond_c` always equal register bits 3, 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code (see R3, R7, R10) |
| op_size | input | 2 | Width select: 0 byte, 1 word, 2/3 long |
| src_a | input | 32 | First operand (minuend for subtract forms) |
| src_b | input | 32 | Second operand (subtrahend, or negate operand) |
| result | input | 32 | Datapath result of the operation |
| imm | input | 8 | Immediate byte for register operations |
| exc_entry | input | 1 | Exception-handling sequence starts |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| sr_q | output | 8 | Current status register |
| cond_n | output | 1 | Negative flag |
| cond_z | output | 1 | Zero flag |
| cond_v | output | 1 | Overflow flag |
| cond_c | output | 1 | Carry flag |
| irq_grant | output | 1 | Maskable request passed the mask |
| nmi_grant | output | 1 | Non-maskable request passed |

## Verification
Two situations are hard to reach from the ports. The first is the carry-chained zero rule, where an add-with-carry or subtract-with-borrow yields an all-zero result and the previous zero flag must survive. That needs a known zero flag and carry beforehand. The stimulus first loads an immediate that fixes both, then issues the chained operation, including a borrow case where 0 − 0xFF − 1 wraps to zero. The second is an exception entry in the same cycle as a register load or an arithmetic operation. The bench drives both strobes together and checks the merged register value.

// File: rtl/cc_pkg.sv
package cc_pkg;

  localparam int SR_W    = 8;
  localparam int B_MASK  = 7;
  localparam int B_USR_A = 6;
  localparam int B_HALF  = 5;
  localparam int B_USR_B = 4;
  localparam int B_NEG   = 3;
  localparam int B_ZERO  = 2;
  localparam int B_OVF   = 1;
  localparam int B_CARRY = 0;

  localparam logic [SR_W-1:0] SR_RESET = SR_W'(1) << B_MASK;

  typedef enum logic [3:0] {
    OP_NONE  = 4'd0,
    OP_ADD   = 4'd1,
    OP_ADDC  = 4'd2,
    OP_SUB   = 4'd3,
    OP_SUBC  = 4'd4,
    OP_CMP   = 4'd5,
    OP_NEG   = 4'd6,
    OP_LOAD  = 4'd7,
    OP_STORE = 4'd8,
    OP_AND   = 4'd9,
    OP_OR    = 4'd10,
    OP_XOR   = 4'd11
  } cc_op_e;

  typedef struct packed {
    logic half;
    logic neg;
    logic zero;
    logic ovf;
    logic carry;
  } arith_flags_t;

  function automatic logic op_is_arith(input cc_op_e op);
    return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB) ||
           (op == OP_SUBC) || (op == OP_CMP) || (op == OP_NEG);
  endfunction

  function automatic logic op_is_chained(input cc_op_e op);
    return (op == OP_ADDC) || (op == OP_SUBC);
  endfunction

  function automatic logic op_is_subtract(input cc_op_e op);
    return (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP) || (op == OP_NEG);
  endfunction

endpackage

// File: rtl/cc_size_flags.sv
module cc_size_flags
  import cc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [W-1:0]  res,
  input  logic          sub_mode,
  output arith_flags_t  flags
);

  localparam int HI = W - 1;
  localparam int HC = W - 5;

  // Carry (add) or borrow (subtract) out of each bit, recovered from a, b, r.
  logic [W-1:0] cout;
  logic         sa, sb, sr;
  logic         unused_mid_carries;

  always_comb begin
    if (sub_mode) cout = (~opa & opb) | ((~opa | opb) & res);
    else          cout = (opa & opb) | ((opa | opb) & ~res);
  end

  assign sa = opa[HI];
  assign sb = opb[HI];
  assign sr = res[HI];

  assign flags.half  = cout[HC];
  assign flags.carry = cout[HI];
  assign flags.neg   = sr;
  assign flags.zero  = ~|res;
  assign flags.ovf   = sub_mode ? ((sa ^ sb) & (sa ^ sr))
                                : (~(sa ^ sb) & (sa ^ sr));

  assign unused_mid_carries = ^cout;

endmodule

// File: rtl/cc_flag_select.sv
module cc_flag_select
  import cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] res,
  input  logic              sub_mode,
  input  logic [1:0]        size_sel,
  output arith_flags_t      flags
);

  localparam int NSIZE = 3;

  arith_flags_t per_size [NSIZE];

  for (genvar gi = 0; gi < NSIZE; gi++) begin : g_size
    localparam int W = DATA_W >> (NSIZE - 1 - gi);
    cc_size_flags #(.W(W)) u_size (
      .opa      (opa[W-1:0]),
      .opb      (opb[W-1:0]),
      .res      (res[W-1:0]),
      .sub_mode (sub_mode),
      .flags    (per_size[gi])
    );
  end

  always_comb begin
    case (size_sel)
      2'd0:    flags = per_size[0];
      2'd1:    flags = per_size[1];
      default: flags = per_size[2];
    endcase
  end

endmodule

// File: rtl/cc_reg_update.sv
module cc_reg_update
  import cc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  cc_op_e          op,
  input  arith_flags_t    flags,
  input  logic [SR_W-1:0] imm,
  input  logic            exc_entry,
  output logic [SR_W-1:0] sr_q
);

  logic [SR_W-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (op_valid) begin
      case (op)
        OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP, OP_NEG: begin
          sr_d[B_HALF]  = flags.half;
          sr_d[B_NEG]   = flags.neg;
          sr_d[B_ZERO]  = op_is_chained(op) ? (sr_q[B_ZERO] & flags.zero) : flags.zero;
          sr_d[B_OVF]   = flags.ovf;
          sr_d[B_CARRY] = flags.carry;
        end
        OP_LOAD: sr_d = imm;
        OP_AND:  sr_d = sr_q & imm;
        OP_OR:   sr_d = sr_q | imm;
        OP_XOR:  sr_d = sr_q ^ imm;
        default: sr_d = sr_q;
      endcase
    end
    if (exc_entry) sr_d[B_MASK] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= SR_RESET;
    else        sr_q <= sr_d;
  end

  assert_exc_sets_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> sr_q[B_MASK]);

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !exc_entry) |=> $stable(sr_q));

  assert_and_merges_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_AND && !exc_entry) |=> sr_q == ($past(sr_q) & $past(imm)));

  assert_arith_keeps_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_is_arith(op) && !exc_entry) |=>
      (sr_q[B_MASK] == $past(sr_q[B_MASK])) && (sr_q[B_USR_A] == $past(sr_q[B_USR_A])) &&
      (sr_q[B_USR_B] == $past(sr_q[B_USR_B])));

endmodule

// File: rtl/cc_flag_unit.sv
module cc_flag_unit
  import cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [1:0]        op_size,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] result,
  input  logic [SR_W-1:0]   imm,
  input  logic              exc_entry,
  input  logic              irq_req,
  input  logic              nmi_req,
  output logic [SR_W-1:0]   sr_q,
  output logic              cond_n,
  output logic              cond_z,
  output logic              cond_v,
  output logic              cond_c,
  output logic              irq_grant,
  output logic              nmi_grant
);

  cc_op_e            op_e;
  logic [DATA_W-1:0] eff_a;
  logic              sub_mode;
  arith_flags_t      flags;

  assign op_e     = cc_op_e'(op_code);
  assign eff_a    = (op_e == OP_NEG) ? '0 : src_a;
  assign sub_mode = op_is_subtract(op_e);

  cc_flag_select #(.DATA_W(DATA_W)) u_select (
    .opa      (eff_a),
    .opb      (src_b),
    .res      (result),
    .sub_mode (sub_mode),
    .size_sel (op_size),
    .flags    (flags)
  );

  cc_reg_update u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op        (op_e),
    .flags     (flags),
    .imm       (imm),
    .exc_entry (exc_entry),
    .sr_q      (sr_q)
  );

  assign cond_n    = sr_q[B_NEG];
  assign cond_z    = sr_q[B_ZERO];
  assign cond_v    = sr_q[B_OVF];
  assign cond_c    = sr_q[B_CARRY];
  assign irq_grant = irq_req & ~sr_q[B_MASK];
  assign nmi_grant = nmi_req;

  assert_byte_neg_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_size == 2'd0 && (op_e == OP_ADD || op_e == OP_SUB)) |=>
      sr_q[B_NEG] == $past(result[7]));

endmodule

// File: tb/cc_flag_unit_tb_top.sv
module cc_flag_unit_tb_top;

  localparam logic [3:0] C_NONE = 4'd0, C_ADD = 4'd1, C_ADDC = 4'd2, C_SUB = 4'd3,
                         C_SUBC = 4'd4, C_CMP = 4'd5, C_NEG = 4'd6, C_LOAD = 4'd7,
                         C_STORE = 4'd8, C_AND = 4'd9, C_OR = 4'd10, C_XOR = 4'd11;

  logic        clk = 1'b0;
  logic        rst_n, op_valid, exc_entry, irq_req, nmi_req;
  logic [3:0]  op_code;
  logic [1:0]  op_size;
  logic [31:0] src_a, src_b, result;
  logic [7:0]  imm, sr_q, exp_sr;
  logic        cond_n, cond_z, cond_v, cond_c, irq_grant, nmi_grant;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cc_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_size(op_size),
    .src_a(src_a), .src_b(src_b), .result(result), .imm(imm), .exc_entry(exc_entry),
    .irq_req(irq_req), .nmi_req(nmi_req), .sr_q(sr_q), .cond_n(cond_n), .cond_z(cond_z),
    .cond_v(cond_v), .cond_c(cond_c), .irq_grant(irq_grant), .nmi_grant(nmi_grant)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk(tag, {24'h0, sr_q}, {24'h0, exp_sr});
    chk({tag, " R11 cond lines"}, {28'h0, cond_n, cond_z, cond_v, cond_c}, {28'h0, exp_sr[3:0]});
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    op_valid  = 1'b0;
    exc_entry = 1'b0;
  endtask

  // Flag model from the requirements: wide arithmetic, then bit extraction.
  function automatic logic [7:0] model(input logic [3:0] op, input logic [1:0] sz,
                                       input logic [31:0] a, input logic [31:0] b,
                                       input logic [7:0] sr, output logic [31:0] r);
    int     w;
    longint m, hm, aa, bb, cin, full, hf;
    logic   h, c, n, z, v, sa, sb, sr_b, is_add;
    w      = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m      = (longint'(1) << w) - 1;
    hm     = (longint'(1) << (w - 4)) - 1;
    cin    = (op == C_ADDC || op == C_SUBC) ? longint'(sr[0]) : 0;
    aa     = (op == C_NEG) ? 0 : (longint'(a) & m);
    bb     = longint'(b) & m;
    is_add = (op == C_ADD || op == C_ADDC);
    if (is_add) begin
      full = aa + bb + cin;
      hf   = (aa & hm) + (bb & hm) + cin;
      c    = ((full >> w) & 1) != 0;
      h    = ((hf >> (w - 4)) & 1) != 0;
    end else begin
      full = aa - bb - cin;
      hf   = (aa & hm) - (bb & hm) - cin;
      c    = full < 0;
      h    = hf < 0;
    end
    r    = 32'(full & m);
    sa   = ((aa >> (w - 1)) & 1) != 0;
    sb   = ((bb >> (w - 1)) & 1) != 0;
    sr_b = ((longint'(r) >> (w - 1)) & 1) != 0;
    n    = sr_b;
    z    = (r == 32'h0);
    if (op == C_ADDC || op == C_SUBC) z = sr[2] & z;
    v    = is_add ? ((sa == sb) && (sr_b != sa)) : ((sa != sb) && (sr_b != sa));
    return {sr[7], sr[6], h, sr[4], n, z, v, c};
  endfunction

  task automatic arith(input logic [3:0] op, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] junk, input logic ex,
                       input string tag);
    logic [31:0] r, m;
    logic [7:0]  nxt;
    nxt = model(op, sz, a, b, exp_sr, r);
    m   = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    op_valid = 1'b1; op_code = op; op_size = sz;
    src_a = a; src_b = b; result = r | (junk & ~m); exc_entry = ex;
    step();
    exp_sr = nxt;
    if (ex) exp_sr[7] = 1'b1;
    chk_state(tag);
  endtask

  task automatic regop(input logic [3:0] op, input logic [7:0] val, input logic ex,
                       input string tag);
    op_valid = 1'b1; op_code = op; imm = val; exc_entry = ex;
    step();
    case (op)
      C_LOAD:  exp_sr = val;
      C_AND:   exp_sr = exp_sr & val;
      C_OR:    exp_sr = exp_sr | val;
      C_XOR:   exp_sr = exp_sr ^ val;
      default: exp_sr = exp_sr;
    endcase
    if (ex) exp_sr[7] = 1'b1;
    chk_state(tag);
  endtask

  task automatic t_reset();
    irq_req = 1'b1; nmi_req = 1'b1;
    exp_sr = 8'h80;
    chk_state("R1 reset value");
    chk("R9 irq blocked after reset", {31'h0, irq_grant}, 32'h0);
    chk("R9 nmi passes", {31'h0, nmi_grant}, 32'h1);
  endtask

  task automatic t_regops();
    regop(C_LOAD, 8'h00, 1'b0, "R7 load zero");
    chk("R9 irq passes with mask clear", {31'h0, irq_grant}, 32'h1);
    regop(C_LOAD, 8'h3C, 1'b0, "R7 load 3C");
    regop(C_AND, 8'hF0, 1'b0, "R7 and F0");
    regop(C_OR, 8'h05, 1'b0, "R7 or 05");
    regop(C_XOR, 8'hFF, 1'b0, "R7 xor FF");
    chk("R9 irq blocked by xor-set mask", {31'h0, irq_grant}, 32'h0);
    regop(C_STORE, 8'h00, 1'b0, "R7 store keeps value");
    regop(C_LOAD, 8'h40, 1'b0, "R7 load user bit A");
    chk("R9 user bit A does not mask", {31'h0, irq_grant}, 32'h1);
    nmi_req = 1'b0;
    #1 chk("R9 nmi follows request low", {31'h0, nmi_grant}, 32'h0);
    nmi_req = 1'b1;
  endtask

  task automatic t_idle();
    op_code = C_LOAD; imm = 8'hFF; op_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk_state("R10 invalid op ignored");
    regop(C_NONE, 8'hFF, 1'b0, "R10 code zero ignored");
    regop(4'd13, 8'hFF, 1'b0, "R10 unused code ignored");
  endtask

  task automatic t_byte();
    regop(C_LOAD, 8'h50, 1'b0, "R7 preload user bits");
    arith(C_ADD, 2'd0, 32'hABCD_120F, 32'h5555_3301, 32'hDEAD_BE00, 1'b0, "R3 byte add half carry");
    arith(C_ADD, 2'd0, 32'h0000_007F, 32'h0000_0001, 32'h1234_5600, 1'b0, "R4 byte add overflow");
    arith(C_ADD, 2'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_FF00, 1'b0, "R2 byte add wraps to zero");
    chk("R6 user bits kept", {30'h0, sr_q[6], sr_q[4]}, 32'h3);
    arith(C_SUB, 2'd0, 32'h10, 32'h01, 32'h0, 1'b0, "R3 byte sub half borrow");
    arith(C_SUB, 2'd0, 32'h80, 32'h01, 32'h0, 1'b0, "R4 byte sub overflow");
    arith(C_CMP, 2'd0, 32'h05, 32'h05, 32'h0, 1'b0, "R3 byte compare equal");
    arith(C_NEG, 2'd0, 32'hFFFF_FFFF, 32'h01, 32'h0, 1'b0, "R3 byte negate one");
    arith(C_NEG, 2'd0, 32'h0, 32'h80, 32'h0, 1'b0, "R4 byte negate min");
  endtask

  task automatic t_word_long();
    arith(C_ADD, 2'd1, 32'h0FFF, 32'h0001, 32'hABCD_0000, 1'b0, "R3 word half carry bit 11");
    arith(C_ADD, 2'd1, 32'h7FFF, 32'h0001, 32'h0, 1'b0, "R4 word overflow");
    arith(C_SUB, 2'd1, 32'h0000, 32'h0001, 32'h0, 1'b0, "R4 word borrow");
    arith(C_NEG, 2'd1, 32'h0, 32'h1000, 32'h0, 1'b0, "R3 word negate");
    arith(C_ADD, 2'd2, 32'h0FFF_FFFF, 32'h1, 32'h0, 1'b0, "R3 long half carry bit 27");
    arith(C_ADD, 2'd3, 32'hFFFF_FFFF, 32'h1, 32'h0, 1'b0, "R2 long carry and zero");
    arith(C_SUB, 2'd2, 32'h8000_0000, 32'h1, 32'h0, 1'b0, "R4 long sub overflow");
    arith(C_CMP, 2'd2, 32'h1234_5678, 32'h1234_5679, 32'h0, 1'b0, "R4 long compare borrow");
  endtask

  task automatic t_chained();
    regop(C_LOAD, 8'h04, 1'b0, "R5 preload zero set carry clear");
    arith(C_ADDC, 2'd0, 32'h0, 32'h0, 32'h0, 1'b0, "R5 add-with-carry zero keeps Z");
    arith(C_ADDC, 2'd0, 32'h1, 32'h0, 32'h0, 1'b0, "R5 add-with-carry nonzero clears Z");
    arith(C_ADDC, 2'd0, 32'h0, 32'h0, 32'h0, 1'b0, "R5 add-with-carry zero keeps clear Z");
    regop(C_LOAD, 8'h05, 1'b0, "R5 preload zero and carry");
    arith(C_SUBC, 2'd0, 32'h00, 32'hFF, 32'h0, 1'b0, "R5 sub-with-borrow wraps to zero");
    arith(C_SUBC, 2'd1, 32'h0010, 32'h0001, 32'h0, 1'b0, "R5 word sub-with-borrow");
  endtask

  task automatic t_exception();
    regop(C_LOAD, 8'h00, 1'b0, "R8 clear before exception");
    regop(C_NONE, 8'h00, 1'b1, "R8 exception sets mask");
    chk("R9 irq blocked after exception", {31'h0, irq_grant}, 32'h0);
    regop(C_LOAD, 8'h15, 1'b1, "R8 exception with load");
    regop(C_LOAD, 8'h00, 1'b0, "R8 clear again");
    arith(C_ADD, 2'd0, 32'h7F, 32'h01, 32'h0, 1'b1, "R8 exception with add");
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 40; i++) begin
      logic [3:0] op;
      logic [1:0] sz;
      op = 4'(1 + ($urandom % 6));
      sz = 2'($urandom % 4);
      arith(op, sz, $urandom, $urandom, $urandom, 1'b0, "R2 R3 R4 sweep");
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; exc_entry = 1'b0; irq_req = 1'b0; nmi_req = 1'b0;
    op_code = 4'd0; op_size = 2'd0; src_a = '0; src_b = '0; result = '0; imm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regops();
    t_idle();
    t_byte();
    t_word_long();
    t_chained();
    t_exception();
    t_sweep();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule